// File: doc/BRIEF.md
# Data Cache Update Policy Unit

This block decides what the data cache does for each data access presented to it: whether the lookup result stands, whether a matching line is rewritten with the access data, whether a new line is allocated, or whether the cache is bypassed entirely. It takes a qualified access with a kind code, the hit result from the tag comparison, a write-allocate enable, and the two external caching-control inputs: a lockout that keeps an access out of the cache, and an inhibit that marks the responding device as unable to supply full-width data.

Two kinds of access have their own rules. The read half of an atomic read-modify-write is always reported as a miss. Even so, its data can rewrite a matching line or fill a fresh one, but only when neither caching-control input is asserted. Page-table walk accesses are invisible to the cache. The decision is computed combinationally and registered, so each result appears one clock after its access and is held for exactly one cycle.

Top module: `dcp_policy_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all three outputs are low after that edge, whatever the access inputs.
- R2: When `acc_valid` is low, or `acc_kind` holds an unused code (5, 6 or 7), all three outputs are low one cycle later.
- R3: A plain read (`acc_kind` = 0) never raises `force_miss` and never updates. On a hit it does nothing. On a miss it allocates only when `ext_lockout` and `ext_inhibit` are both low.
- R4: A plain write (`acc_kind` = 1) that hits raises `upd_strobe`, regardless of the caching-control inputs.
- R5: A plain write that misses raises `alloc_strobe` when `wr_alloc_en` is high, and leaves the cache untouched when it is low.
- R6: The read half of a read-modify-write (`acc_kind` = 2) always raises `force_miss`, even when the tag compare hits.
- R7: A read-modify-write read with both caching-control inputs low raises `upd_strobe` on a hit and `alloc_strobe` on a miss.
- R8: A read-modify-write read with either `ext_lockout` or `ext_inhibit` high neither updates nor allocates.
- R9: The write half of a read-modify-write (`acc_kind` = 3) raises `upd_strobe` on a hit and never allocates on a miss, even with `wr_alloc_en` high.
- R10: A table-search access (`acc_kind` = 4) raises `force_miss` and never raises `upd_strobe` or `alloc_strobe`, whatever the hit or write-allocate inputs.
- R11: `upd_strobe` and `alloc_strobe` are never high together. Every result appears exactly one clock after its access and lasts one clock when the next cycle is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 3 | Access kind: 0 read, 1 write, 2 atomic read, 3 atomic write, 4 table search |
| tag_hit | input | 1 | Tag compare found a matching valid line |
| wr_alloc_en | input | 1 | Allocate on plain write miss |
| ext_lockout | input | 1 | External request to keep this access out of the cache |
| ext_inhibit | input | 1 | External marking of the data as not cacheable |
| force_miss | output | 1 | Lookup must be treated as a miss (registered) |
| upd_strobe | output | 1 | Rewrite the matching line (registered, one clock) |
| alloc_strobe | output | 1 | Create a new line for this data (registered, one clock) |

## Verification
Every result is due one rising edge after the access that causes it, because there is a single register stage and no other state. The bench drives each access on a falling edge and samples all three outputs on the next falling edge. That edge follows exactly one rising edge, so each sample shows the decision for that access and nothing older. The one-clock strobe width is checked by following an updating access with an idle cycle and sampling one further falling edge later, where both strobes must be low.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int KIND_W = 3;

  localparam logic [KIND_W-1:0] KIND_READ   = 3'd0;
  localparam logic [KIND_W-1:0] KIND_WRITE  = 3'd1;
  localparam logic [KIND_W-1:0] KIND_RMW_RD = 3'd2;
  localparam logic [KIND_W-1:0] KIND_RMW_WR = 3'd3;
  localparam logic [KIND_W-1:0] KIND_TABLE  = 3'd4;

  // one-hot classification of a qualified access
  typedef struct packed {
    logic rd;
    logic wr;
    logic rmw_rd;
    logic rmw_wr;
    logic tbl;
  } kind_flags_t;

  typedef struct packed {
    logic miss;
    logic upd;
    logic alc;
  } decision_t;

  localparam int DEC_W = $bits(decision_t);
endpackage

// File: rtl/dcp_classify.sv
module dcp_classify
  import dcp_pkg::*;
(
  input  logic              valid,
  input  logic [KIND_W-1:0] kind,
  output kind_flags_t       flags
);
  always_comb begin
    flags = '0;
    if (valid) begin
      case (kind)
        KIND_READ:   flags.rd     = 1'b1;
        KIND_WRITE:  flags.wr     = 1'b1;
        KIND_RMW_RD: flags.rmw_rd = 1'b1;
        KIND_RMW_WR: flags.rmw_wr = 1'b1;
        KIND_TABLE:  flags.tbl    = 1'b1;
        default:     flags        = '0;
      endcase
    end
  end

  always_comb begin
    flags_onehot_chk: assert ($onehot0(flags));
  end
endmodule

// File: rtl/dcp_rules.sv
module dcp_rules
  import dcp_pkg::*;
(
  input  kind_flags_t flags,
  input  logic        hit,
  input  logic        wa,
  input  logic        lockout,
  input  logic        inhibit,
  output decision_t   dec
);
  logic cacheable;
  assign cacheable = !lockout && !inhibit;

  always_comb begin
    dec = '0;
    if (flags.rd) begin
      dec.alc = !hit && cacheable;
    end
    if (flags.wr) begin
      dec.upd = hit;
      dec.alc = !hit && wa;
    end
    if (flags.rmw_rd) begin
      dec.miss = 1'b1;
      dec.upd  = hit && cacheable;
      dec.alc  = !hit && cacheable;
    end
    if (flags.rmw_wr) begin
      dec.upd = hit;
    end
    if (flags.tbl) begin
      dec.miss = 1'b1;
    end
  end

  // R11
  always_comb begin
    upd_alc_excl_chk: assert (!(dec.upd && dec.alc));
  end
endmodule

// File: rtl/dcp_outreg.sv
module dcp_outreg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/dcp_policy_unit.sv
module dcp_policy_unit
  import dcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [KIND_W-1:0] acc_kind,
  input  logic              tag_hit,
  input  logic              wr_alloc_en,
  input  logic              ext_lockout,
  input  logic              ext_inhibit,
  output logic              force_miss,
  output logic              upd_strobe,
  output logic              alloc_strobe
);
  kind_flags_t flags;
  decision_t   dec_c;
  logic [DEC_W-1:0] dec_q;

  dcp_classify u_cls (
    .valid (acc_valid),
    .kind  (acc_kind),
    .flags (flags)
  );

  dcp_rules u_rules (
    .flags   (flags),
    .hit     (tag_hit),
    .wa      (wr_alloc_en),
    .lockout (ext_lockout),
    .inhibit (ext_inhibit),
    .dec     (dec_c)
  );

  dcp_outreg #(.W(DEC_W)) u_oreg (
    .clk (clk),
    .rst (rst),
    .d   (dec_c),
    .q   (dec_q)
  );

  decision_t dec_o;
  assign dec_o        = decision_t'(dec_q);
  assign force_miss   = dec_o.miss;
  assign upd_strobe   = dec_o.upd;
  assign alloc_strobe = dec_o.alc;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!force_miss && !upd_strobe && !alloc_strobe));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(upd_strobe && alloc_strobe));

  // R6
  rmw_rd_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == KIND_RMW_RD) |=> force_miss);

  // R8
  rmw_rd_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == KIND_RMW_RD && (ext_lockout || ext_inhibit))
      |=> (!upd_strobe && !alloc_strobe));

  // R10
  table_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == KIND_TABLE)
      |=> (force_miss && !upd_strobe && !alloc_strobe));

  // R5
  wr_miss_noalloc_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == KIND_WRITE && !tag_hit && !wr_alloc_en)
      |=> (!upd_strobe && !alloc_strobe));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!force_miss && !upd_strobe && !alloc_strobe));
endmodule

// File: tb/dcp_policy_unit_test.sv
module dcp_policy_unit_test;
  logic clk = 1'b0;
  logic rst;
  logic acc_valid;
  logic [2:0] acc_kind;
  logic tag_hit, wr_alloc_en, ext_lockout, ext_inhibit;
  logic force_miss, upd_strobe, alloc_strobe;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dcp_policy_unit uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .tag_hit(tag_hit), .wr_alloc_en(wr_alloc_en), .ext_lockout(ext_lockout),
    .ext_inhibit(ext_inhibit), .force_miss(force_miss),
    .upd_strobe(upd_strobe), .alloc_strobe(alloc_strobe)
  );

  // {req[3:0], valid, kind[2:0], hit, wa, lockout, inhibit, exp miss, upd, alc}
  localparam int NV = 19;
  localparam logic [14:0] VEC [NV] = '{
    {4'd3,  1'b1, 3'd0, 4'b1000, 3'b000},  // R3 read hit
    {4'd3,  1'b1, 3'd0, 4'b0000, 3'b001},  // R3 read miss cacheable
    {4'd3,  1'b1, 3'd0, 4'b0010, 3'b000},  // R3 read miss lockout
    {4'd3,  1'b1, 3'd0, 4'b0001, 3'b000},  // R3 read miss inhibit
    {4'd4,  1'b1, 3'd1, 4'b1000, 3'b010},  // R4 write hit
    {4'd4,  1'b1, 3'd1, 4'b1011, 3'b010},  // R4 write hit both controls
    {4'd5,  1'b1, 3'd1, 4'b0100, 3'b001},  // R5 write miss allocate
    {4'd5,  1'b1, 3'd1, 4'b0000, 3'b000},  // R5 write miss no allocate
    {4'd6,  1'b1, 3'd2, 4'b1000, 3'b110},  // R6 R7 rmw read hit
    {4'd7,  1'b1, 3'd2, 4'b0000, 3'b101},  // R7 rmw read miss
    {4'd8,  1'b1, 3'd2, 4'b1010, 3'b100},  // R8 lockout
    {4'd8,  1'b1, 3'd2, 4'b0001, 3'b100},  // R8 inhibit
    {4'd9,  1'b1, 3'd3, 4'b1000, 3'b010},  // R9 rmw write hit
    {4'd9,  1'b1, 3'd3, 4'b0100, 3'b000},  // R9 rmw write miss
    {4'd10, 1'b1, 3'd4, 4'b1100, 3'b100},  // R10 table hit
    {4'd10, 1'b1, 3'd4, 4'b0100, 3'b100},  // R10 table miss
    {4'd2,  1'b0, 3'd1, 4'b1000, 3'b000},  // R2 not valid
    {4'd2,  1'b1, 3'd5, 4'b1100, 3'b000},  // R2 unused code
    {4'd2,  1'b1, 3'd7, 4'b0100, 3'b000}   // R2 unused code
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {miss,upd,alc} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] k, input logic [3:0] c);
    acc_valid = v;
    acc_kind = k;
    {tag_hit, wr_alloc_en, ext_lockout, ext_inhibit} = c;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b1, 3'd1, 4'b1000);
    // R1: reset holds outputs low even with an updating access present
    @(negedge clk);
    @(negedge clk);
    check("R1", {force_miss, upd_strobe, alloc_strobe}, 3'b000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][10], VEC[i][9:7], VEC[i][6:3]);
      @(negedge clk);
      check($sformatf("R%0d", VEC[i][14:11]),
            {force_miss, upd_strobe, alloc_strobe}, VEC[i][2:0]);
      // R11 exclusivity on every sample
      check("R11", {1'b0, upd_strobe && alloc_strobe, 1'b0}, 3'b000);
    end

    // R11: one-clock strobe then idle
    @(negedge clk);
    drive(1'b1, 3'd1, 4'b0100);
    @(negedge clk);
    check("R11", {force_miss, upd_strobe, alloc_strobe}, 3'b001);
    drive(1'b0, 3'd0, 4'b0000);
    @(negedge clk);
    check("R11", {force_miss, upd_strobe, alloc_strobe}, 3'b000);

    // R7 then R10 back to back: each result lands in its own cycle
    drive(1'b1, 3'd2, 4'b1000);
    @(negedge clk);
    check("R7", {force_miss, upd_strobe, alloc_strobe}, 3'b110);
    drive(1'b1, 3'd4, 4'b1000);
    @(negedge clk);
    check("R10", {force_miss, upd_strobe, alloc_strobe}, 3'b100);

    // R1: reset asserted mid-run over an allocating access
    drive(1'b1, 3'd2, 4'b0000);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {force_miss, upd_strobe, alloc_strobe}, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    check("R7", {force_miss, upd_strobe, alloc_strobe}, 3'b101);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule